// File: doc/BRIEF.md
# Variable-Section Carry-Select Adder

This block adds two 64-bit operands and a carry-in in one combinational pass. It yields the 64-bit sum, the carry out of the top bit, and a flag for two's-complement overflow. The same sum bits serve unsigned and signed callers. The caller chooses which of the carry-out and the overflow flag to use.

The operand is cut into seven sections. From the least significant end their widths are 7, 7, 8, 9, 10, 11 and 12 bits. The bottom section is a single ripple chain fed by the external carry-in. Every higher section holds two ripple chains. One assumes an incoming carry of 0 and the other assumes 1. The real carry from the section below picks between the two results, for both the sum bits and the section's carry-out. The sections get wider towards the top because a carry reaches a higher section later, so that section's own ripple has more time to finish. The block has no clock, reset or state.

Top module: `csel_adder64`

## Requirements
- R1: `sumOut` equals (`opA` + `opB` + `carryIn`) modulo 2^64 for every input combination.
- R2: `carryOut` equals bit 64 of the unbounded sum `opA` + `opB` + `carryIn`. It is 1 exactly when the unsigned result does not fit in 64 bits.
- R3: `ovfFlag` is 1 exactly when the signed sum of `opA`, `opB` (both read as two's complement) and `carryIn` lies outside the range -2^63 to 2^63-1. This is the same as the carry into bit 63 differing from the carry out of bit 63. Examples: 0x7FFF_FFFF_FFFF_FFFF + 1 sets it, and 0x8000_0000_0000_0000 + 0xFFFF_FFFF_FFFF_FFFF sets it together with `carryOut`.
- R4: The operand is split into sections of widths 7, 7, 8, 9, 10, 11 and 12 bits, starting at bit 0. Elaboration fails if the widths do not add up to the data width.
- R5: A carry produced in any section reaches every section above it. Low ones in bits 0 to k-1, with the rest of `opA` zero, `opB` zero and `carryIn` 1, give a sum of exactly 2^k. This holds at each section boundary k = 7, 14, 22, 31, 41 and 52, and with k = 64 the sum is 0 and `carryOut` is 1.
- R6: In each upper section, the copy that assumes carry-in 1 produces the result of the copy that assumes carry-in 0, plus one.
- R7: The outputs depend only on the present inputs. A new input value is reflected on all outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 64 | Sum modulo 2^64 |
| carryOut | output | 1 | Carry out of bit 63 |
| ovfFlag | output | 1 | Two's-complement overflow |

## Verification
On every input change, the embedded assertions check four things. Each ripple chain must match arithmetic addition of its slice. The two copies inside each upper section must differ by exactly one. Every section's carry-out and top sum bit must agree with its top operand bits. The overflow flag must match the sign rule.

Some behaviours only the bench's scenarios can show. One is that carries really cross each of the six section boundaries into the right section. Others are the named corners: all-ones plus one, the largest positive plus one, the most negative plus minus one, and all-ones operands with carry-in set. The last is that the outputs settle without any clock edge.

// File: rtl/csa_pkg.sv
package csa_pkg;

  localparam int NUM_SECT = 7;

  // R4: section widths, least significant first
  localparam int SECT_W [NUM_SECT] = '{7, 7, 8, 9, 10, 11, 12};

  // lowest bit index of section s
  function automatic int sectLo(input int s);
    int lo;
    lo = 0;
    for (int i = 0; i < s; i++) lo += SECT_W[i];
    return lo;
  endfunction

  function automatic int totalWidth();
    return sectLo(NUM_SECT);
  endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         topCin
);

  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic half;
    assign half         = a[i] ^ b[i];
    assign sum[i]       = half ^ carry[i];
    assign carry[i+1]   = (a[i] & b[i]) | (carry[i] & half);
  end

  assign cout   = carry[W];
  assign topCin = carry[W-1];

  always_comb begin
    // R1
    ripple_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (W+1)'(cin)))
      else $error("ripple slice result differs from arithmetic sum");
  end

endmodule

// File: rtl/csa_select.sv
module csa_select #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         topCin
);

  logic [W-1:0] sumLo, sumHi;
  logic         coutLo, coutHi;
  logic         topLo, topHi;

  csa_ripple #(.W(W)) u_assume0 (
    .a(a), .b(b), .cin(1'b0),
    .sum(sumLo), .cout(coutLo), .topCin(topLo)
  );

  csa_ripple #(.W(W)) u_assume1 (
    .a(a), .b(b), .cin(1'b1),
    .sum(sumHi), .cout(coutHi), .topCin(topHi)
  );

  assign sum    = cin ? sumHi  : sumLo;
  assign cout   = cin ? coutHi : coutLo;
  assign topCin = cin ? topHi  : topLo;

  always_comb begin
    // R6
    copy_pair_chk: assert ({coutHi, sumHi} == ({coutLo, sumLo} + (W+1)'(1)))
      else $error("carry-in-1 copy is not carry-in-0 copy plus one");
  end

endmodule

// File: rtl/csel_adder64.sv
module csel_adder64 #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] sumOut,
  output logic              carryOut,
  output logic              ovfFlag
);

  localparam int NS = csa_pkg::NUM_SECT;

  // R4: elaboration-time width check
  if (csa_pkg::totalWidth() != DATA_W) begin : g_width_bad
    $error("section widths do not add up to DATA_W");
  end

  logic [NS:0]   chain;
  logic [NS-1:0] secTop;

  assign chain[0] = carryIn;

  for (genvar s = 0; s < NS; s++) begin : g_sect
    localparam int W  = csa_pkg::SECT_W[s];
    localparam int LO = csa_pkg::sectLo(s);
    localparam int HI = LO + W - 1;

    if (s == 0) begin : g_base
      csa_ripple #(.W(W)) u_rip (
        .a(opA[LO +: W]), .b(opB[LO +: W]), .cin(chain[s]),
        .sum(sumOut[LO +: W]), .cout(chain[s+1]), .topCin(secTop[s])
      );
    end else begin : g_sel
      csa_select #(.W(W)) u_sel (
        .a(opA[LO +: W]), .b(opB[LO +: W]), .cin(chain[s]),
        .sum(sumOut[LO +: W]), .cout(chain[s+1]), .topCin(secTop[s])
      );
    end

    always_comb begin
      // R5
      sect_top_chk: assert ({chain[s+1], sumOut[HI]} ==
                            (2'(opA[HI]) + 2'(opB[HI]) + 2'(secTop[s])))
        else $error("section top bit and carry disagree");
      // R5
      sect_link_chk: assert ({chain[s+1], sumOut[LO +: W]} ==
                             ({1'b0, opA[LO +: W]} + {1'b0, opB[LO +: W]} + (W+1)'(chain[s])))
        else $error("section result ignores incoming carry");
    end
  end

  assign carryOut = chain[NS];
  assign ovfFlag  = chain[NS] ^ secTop[NS-1];

  always_comb begin
    // R3
    overflow_sign_chk: assert (ovfFlag == ((opA[DATA_W-1] == opB[DATA_W-1]) &&
                                           (sumOut[DATA_W-1] != opA[DATA_W-1])))
      else $error("overflow flag disagrees with sign rule");
    // R1
    full_sum_chk: assert ({carryOut, sumOut} ==
                          ({1'b0, opA} + {1'b0, opB} + (DATA_W+1)'(carryIn)))
      else $error("full sum mismatch");
  end

endmodule

// File: tb/csel_adder64_bench.sv
module csel_adder64_bench;

  logic        clk = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [63:0] sumOut;
  logic        carryOut;
  logic        ovfFlag;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  csel_adder64 u_csel_adder64 (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut), .ovfFlag(ovfFlag)
  );

  function automatic logic [64:0] refSum(input logic [63:0] a, input logic [63:0] b, input logic c);
    return {1'b0, a} + {1'b0, b} + {64'd0, c};
  endfunction

  function automatic logic refOvf(input logic [63:0] a, input logic [63:0] b, input logic c);
    logic [65:0] wide;
    wide = {{2{a[63]}}, a} + {{2{b[63]}}, b} + {65'd0, c};
    return !(wide[65] == wide[64] && wide[64] == wide[63]);
  endfunction

  task automatic checkOut(input string tag, input logic [63:0] expSum, input logic expCo, input logic expOv);
    checks++;
    if (sumOut !== expSum) begin
      failures++;
      $display("FAIL %s R1 sum actual=%h expected=%h", tag, sumOut, expSum);
    end
    checks++;
    if (carryOut !== expCo) begin
      failures++;
      $display("FAIL %s R2 carryOut actual=%b expected=%b", tag, carryOut, expCo);
    end
    checks++;
    if (ovfFlag !== expOv) begin
      failures++;
      $display("FAIL %s R3 ovfFlag actual=%b expected=%b", tag, ovfFlag, expOv);
    end
  endtask

  // drive away from the edge, sample 2 ns later with no clock edge between (R7)
  task automatic apply(input string tag, input logic [63:0] a, input logic [63:0] b, input logic c);
    logic [64:0] r;
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    #2;
    r = refSum(a, b, c);
    checkOut(tag, r[63:0], r[64], refOvf(a, b, c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R7 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] ra, rb;
    void'($urandom(32'h5eed_c0de));

    // zero inputs: all outputs low (R1 R2 R3)
    #3;
    checkOut("idle_zero", 64'd0, 1'b0, 1'b0);

    // corner cases
    apply("allones_plus_one R2", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);
    apply("maxpos_plus_one R3", 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);
    apply("minneg_plus_m1 R3", 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    apply("allones_cin R2", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    apply("maxpos_cin R3", 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 1'b1);
    apply("minneg_pair R3", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);

    // R5: carry crosses each section boundary (R4 widths 7,7,8,9,10,11,12)
    foreach (csa_pkg::SECT_W[s]) begin
      int k;
      k = csa_pkg::sectLo(s + 1);
      apply($sformatf("boundary_%0d R5", k),
            (k == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << k) - 64'd1), 64'd0, 1'b1);
    end

    // R7: back-to-back changes within one cycle, each seen immediately
    @(negedge clk);
    opA = 64'h0123_4567_89AB_CDEF; opB = 64'h1111_1111_1111_1111; carryIn = 1'b0;
    #1;
    checkOut("settle_a R7", 64'h1234_5678_9ABC_DF00, 1'b0, 1'b0);
    carryIn = 1'b1;
    #1;
    checkOut("settle_b R7", 64'h1234_5678_9ABC_DF01, 1'b0, 1'b0);

    // random vectors with biased patterns
    for (int n = 0; n < 3000; n++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      case ($urandom % 4)
        0: rb = ~ra;
        1: rb = ra;
        2: ra = ra | 64'hFFFF_FFF0_0000_0000;
        default: ;
      endcase
      apply("random R1", ra, rb, 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule